// File: doc/BRIEF.md
# Shared Memory Host Access Gate

This block judges each host access to a shared memory. It adds a base offset to the host address and keeps 21 bits, so the 2 MB core space wraps. The sum, called the core address, selects a 64 KB host region and a core region. Core regions are 8 KB wide in the lowest 128 KB and 64 KB wide above that. The block then applies fixed rules for three areas: a core boot area at the bottom of the space, a core-private area below 64 KB, and a host boot area in the top 64 KB. Where no fixed rule applies, two sets of deny flags decide. One set is programmed by the host and one by the core.

The inputs are captured on a clock edge. The verdict (allow or deny) and the core address appear on the registered outputs one cycle later. The flag storage is outside this block. It arrives on the flag vectors as plain bits, where a 1 denies the access.

Top module: `shm_host_gate`

## Requirements
- R1: `core_addr` equals (`host_addr` + effective base) modulo 2^21, and appears one clock after the inputs are sampled.
- R2: The effective base is `base_offset`, or zero while `force_base_zero` is 1.
- R3: The host region index is `core_addr[20:16]`. Bit i of `host_rd_deny` denies reads in region i, and bit i of `host_wr_deny` denies writes in region i.
- R4: The core region number is `core_addr[16:13]` (0 to 15) when `core_addr` < 0x20000. Otherwise it is 14 + `core_addr[20:16]` (16 to 45). Bit n of `core_rd_deny` or `core_wr_deny` denies that access type in core region n.
- R5: Every access with `core_addr` < 4096 << min(`cboot_sel`, 9) is denied, whatever the flags say.
- R6: Every access with effective base <= `core_addr` <= 0xFFFF is denied.
- R7: While `hboot_off` is 0 and `core_addr` >= 0x1F0000, writes are denied and reads are allowed, whatever the flags say.
- R8: Where the core boot area covers the host boot area (`cboot_sel` >= 9), reads there are denied as well.
- R9: Any other access is allowed exactly when neither the host flag nor the core flag for its type and region denies it.
- R10: After reset, and until the first sampled access, `allow` is 0, `deny` is 1 and `core_addr` is 0.
- R11: `deny` is always the complement of `allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| host_addr | input | 21 | host address |
| is_write | input | 1 | 1 = write, 0 = read |
| base_offset | input | 21 | base added to host addresses |
| force_base_zero | input | 1 | treat the base as zero |
| hboot_off | input | 1 | 1 removes the host boot area |
| cboot_sel | input | 4 | core boot area size, 4 KB << sel (capped at 2 MB) |
| host_rd_deny | input | 32 | host-programmed read deny, one per 64 KB region |
| host_wr_deny | input | 32 | host-programmed write deny, one per 64 KB region |
| core_rd_deny | input | 46 | core override read deny, one per core region |
| core_wr_deny | input | 46 | core override write deny, one per core region |
| allow | output | 1 | registered verdict: access permitted |
| deny | output | 1 | registered verdict: access refused |
| core_addr | output | 21 | registered core address |

## Verification
Every result of this block (`allow`, `deny` and `core_addr`) is due exactly one clock edge after its inputs are sampled. The bench changes the inputs on the falling edge and lets one rising edge pass. It compares the outputs on the next falling edge, before it drives the following access. The sweeps cover every 2 KB step of the 2 MB space, with both reads and writes, over configurations that exercise each fixed area and the case where the two boot areas overlap.

// File: rtl/shm_host_gate.sv
module shm_host_gate #(
  parameter int AW    = 21,
  parameter int HREGS = 32,
  parameter int CREGS = 46
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   host_addr,
  input  logic            is_write,
  input  logic [AW-1:0]   base_offset,
  input  logic            force_base_zero,
  input  logic            hboot_off,
  input  logic [3:0]      cboot_sel,
  input  logic [HREGS-1:0] host_rd_deny,
  input  logic [HREGS-1:0] host_wr_deny,
  input  logic [CREGS-1:0] core_rd_deny,
  input  logic [CREGS-1:0] core_wr_deny,
  output logic            allow,
  output logic            deny,
  output logic [AW-1:0]   core_addr
);
  localparam int HSH  = 16;
  localparam int CSH  = 13;
  localparam int HIW  = AW - HSH;
  localparam int CIW  = $clog2(CREGS);
  localparam int FINE = 1 << (HSH + 1 - CSH);
  localparam int MAXSEL = AW - 12;

  logic [AW-1:0]  base_eff, xlat;
  logic [HIW-1:0] hidx;
  logic [CIW-1:0] cidx;
  logic [AW:0]    cboot_lim;
  logic           in_cboot, in_priv, in_hboot, flag_deny, ok;

  assign base_eff = force_base_zero ? '0 : base_offset;
  assign xlat     = host_addr + base_eff;
  assign hidx     = xlat[AW-1:HSH];

  assign cidx = (xlat[AW-1:HSH+1] == '0)
              ? CIW'(xlat[HSH:CSH])
              : CIW'(hidx) + CIW'(FINE - 2);

  assign cboot_lim = (cboot_sel >= 4'(MAXSEL))
                   ? ((AW+1)'(1) << AW)
                   : ((AW+1)'(4096) << cboot_sel);

  assign in_cboot  = {1'b0, xlat} < cboot_lim;
  assign in_priv   = (xlat >= base_eff) && (xlat[AW-1:HSH] == '0);
  assign in_hboot  = !hboot_off && (hidx == '1);
  assign flag_deny = is_write ? (host_wr_deny[hidx] | core_wr_deny[cidx])
                              : (host_rd_deny[hidx] | core_rd_deny[cidx]);

  always_comb begin
    if (in_cboot || in_priv) ok = 1'b0;
    else if (in_hboot)       ok = !is_write;
    else                     ok = !flag_deny;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow     <= 1'b0;
      deny      <= 1'b1;
      core_addr <= '0;
    end else begin
      allow     <= ok;
      deny      <= !ok;
      core_addr <= xlat;
    end
  end
endmodule

module shm_host_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [20:0] host_addr,
  input logic        is_write,
  input logic [20:0] base_offset,
  input logic        force_base_zero,
  input logic        hboot_off,
  input logic [3:0]  cboot_sel,
  input logic        allow,
  input logic        deny,
  input logic [20:0] core_addr
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

  assert_verdict_split_R11: assert property (@(posedge clk) disable iff (!rst_n)
    allow != deny);

  assert_addr_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> core_addr == $past(host_addr + (force_base_zero ? 21'd0 : base_offset)));

  assert_cboot_denied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && {1'b0, core_addr} <
      (($past(cboot_sel) >= 4'd9) ? 22'h200000 : (22'd4096 << $past(cboot_sel)))) |-> deny);

  assert_private_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && core_addr <= 21'h0FFFF &&
      core_addr >= ($past(force_base_zero) ? 21'd0 : $past(base_offset))) |-> deny);

  assert_hboot_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(hboot_off) && core_addr >= 21'h1F0000 && $past(is_write)) |-> deny);
endmodule

bind shm_host_gate shm_host_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .is_write(is_write),
  .base_offset(base_offset), .force_base_zero(force_base_zero),
  .hboot_off(hboot_off), .cboot_sel(cboot_sel),
  .allow(allow), .deny(deny), .core_addr(core_addr)
);

// File: tb/shm_host_gate_test.sv
module shm_host_gate_test;
  logic        clk = 0, rst_n = 0;
  logic [20:0] host_addr = 0, base_offset = 0;
  logic        is_write = 0, force_base_zero = 0, hboot_off = 0;
  logic [3:0]  cboot_sel = 0;
  logic [31:0] host_rd_deny = 0, host_wr_deny = 0;
  logic [45:0] core_rd_deny = 0, core_wr_deny = 0;
  logic        allow, deny;
  logic [20:0] core_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shm_host_gate uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %0h wr %0b)", tag, act, exp, host_addr, is_write);
    end
  endtask

  task automatic access(input logic [20:0] a, input logic wr);
    logic [20:0] base, ca;
    logic [5:0]  cn;
    longint      lim;
    bit          ok;
    string       tag;
    host_addr = a; is_write = wr;
    base = force_base_zero ? 21'd0 : base_offset;
    ca   = a + base;
    cn   = (ca < 21'h20000) ? 6'(ca / 8192) : 6'(14 + ca / 65536);
    lim  = (cboot_sel >= 9) ? 64'h200000 : (64'd4096 << cboot_sel);
    if (ca < lim) begin
      ok = 0; tag = (!hboot_off && ca >= 21'h1F0000) ? "R8" : "R5";
    end else if (ca >= base && ca <= 21'h0FFFF) begin
      ok = 0; tag = force_base_zero ? "R2" : "R6";
    end else if (!hboot_off && ca >= 21'h1F0000) begin
      ok = !wr; tag = "R7";
    end else begin
      ok = wr ? !(host_wr_deny[ca/65536] | core_wr_deny[cn])
              : !(host_rd_deny[ca/65536] | core_rd_deny[cn]);
      tag = (ca < 21'h20000) ? "R4" : "R9";
      if (host_rd_deny[ca/65536] || host_wr_deny[ca/65536]) tag = "R3";
    end
    @(negedge clk);
    check("R1", 32'(core_addr), 32'(ca));
    check(tag, 32'(allow), 32'(ok));
    check("R11", 32'(deny), 32'(!allow));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    host_addr = 21'h12345;
    #35;
    check("R10", 32'(allow), 0);
    check("R10", 32'(deny), 1);
    check("R10", 32'(core_addr), 0);
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 10; c++) begin
      force_base_zero = c[0];
      hboot_off       = (c == 3) || (c == 6);
      cboot_sel       = (c == 8) ? 4'd9 : (c == 9) ? 4'd12 : 4'(c % 6);
      base_offset     = 21'($urandom_range(0, 21'h1FFFFF));
      if (c == 2) base_offset = 21'h08000;
      host_rd_deny = $urandom; host_wr_deny = $urandom;
      core_rd_deny = {$urandom, $urandom}; core_wr_deny = {$urandom, $urandom};
      if (c == 4) begin host_rd_deny = 0; host_wr_deny = 0; end
      if (c == 5) begin core_rd_deny = 0; core_wr_deny = 0; host_rd_deny = '1; end
      for (int a = 0; a < 1024; a++) begin
        access(21'(a * 2048 + (c * 331) % 2048), 1'b0);
        access(21'(a * 2048 + (c * 331) % 2048), 1'b1);
      end
    end
    force_base_zero = 1; hboot_off = 0; cboot_sel = 4'd9;
    host_rd_deny = 0; host_wr_deny = 0; core_rd_deny = 0; core_wr_deny = 0;
    access(21'h1F8000, 1'b0);
    access(21'h1FFFFF, 1'b1);
    cboot_sel = 4'd0;
    access(21'h1F8000, 1'b0);
    access(21'h1F8000, 1'b1);
    force_base_zero = 0; base_offset = 21'h1FF000;
    access(21'h001800, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule